// File: doc/BRIEF.md
# Horizontal Sync Window Filter and Regenerator

This block cleans up a raw horizontal sync stream. It learns the line period from the spacing of incoming leading edges. Once the period is stable, it runs a free-running regenerated sync that keeps pulsing at the learned rate through missing or extra input pulses. Around each predicted leading edge it opens an acceptance window of plus or minus `win_x` clock cycles. Input leading edges inside that window pass to the filtered output and pull the regenerator's phase onto the real edge. Edges outside the window are dropped, and they raise a sticky flag that reports extraneous pulses.

Two select inputs route sync to the downstream consumers. The clock-generation output carries either the filtered sync or the raw sync. The sync-processing output carries either the regenerated sync or the raw sync. The raw path is delayed by one register so that it lines up in time with the filtered path. All times are counted in cycles of `clk`. At a 40 MHz clock, one window unit is one cycle.

Top module: `hsync_cleaner`

## Requirements
- R1: After a synchronous active-low reset, all five outputs are low and the block is unlocked.
- R2: While unlocked, every rising edge of `sync_in` is accepted, and `filt_hs` equals `sync_in` delayed by one cycle. Each accepted edge starts a regenerated pulse. `extra_seen` stays low, and the regenerator does not free-run.
- R3: The block locks on an accepted edge when the interval just measured differs by at most 2 cycles from the interval measured before it. The learned period is then set to the latest interval. Two intervals that differ by 3 or more do not lock.
- R4: `regen_hs` rises one cycle after the cycle in which the regenerator fires and stays high for exactly 32 cycles. Once locked, the regenerator fires by itself one learned period after its last reference point when no edge is accepted.
- R5: Once locked, an edge is accepted only if it arrives at most `win_x` cycles before or after the predicted edge. An edge 1 cycle further away in either direction is rejected.
- R6: An accepted edge becomes the new reference, and the next prediction is one period after it. An early accepted edge fires the regenerator at once. A late one, which arrives after the regenerator has already fired, does not fire it again.
- R7: A rejected edge does not appear on `filt_hs`, and it sets `extra_seen`.
- R8: `extra_seen` stays set until `status_clr` is high at a clock edge. A new rejected edge in that same cycle keeps it set.
- R9: `clkgen_hs` carries `filt_hs` when `use_filtered` is 1 and the one-cycle-delayed raw sync when it is 0.
- R10: `proc_hs` carries `regen_hs` when `use_regen` is 1 and the one-cycle-delayed raw sync when it is 0.
- R11: While locked, an accepted edge whose interval from the previous accepted edge is within 2 cycles of the learned period replaces the period. Any other interval leaves the period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Raw horizontal sync, active high |
| win_x | input | 8 | Half-width of the acceptance window in cycles |
| use_filtered | input | 1 | 1: filtered sync on `clkgen_hs`, 0: raw sync |
| use_regen | input | 1 | 1: regenerated sync on `proc_hs`, 0: raw sync |
| status_clr | input | 1 | Clears `extra_seen` |
| filt_hs | output | 1 | Filtered sync |
| regen_hs | output | 1 | Regenerated sync, 32-cycle pulses |
| extra_seen | output | 1 | Sticky flag for out-of-window edges |
| clkgen_hs | output | 1 | Selected sync for clock generation |
| proc_hs | output | 1 | Selected sync for sync processing |

## Verification
The hardest condition to reach is a locked regenerator that receives an edge exactly at, or just past, either border of the window. This needs a learned period, a known reference point and an exact offset, all at the same time. The stimulus gets there by locking on two 100-cycle lines with `win_x` set to 4. It then places the next edge 96, 95, 104 or 105 cycles later. The result is judged from the count of filtered pulses, the flag, and the spacing of the regenerated rising edges, which exposes whether the reference point moved.

// File: rtl/hsync_cleaner.sv
module hsync_cleaner #(
  parameter int CW        = 16,
  parameter int XW        = 8,
  parameter int PULSE_LEN = 32,
  parameter int TOL       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_in,
  input  logic [XW-1:0] win_x,
  input  logic          use_filtered,
  input  logic          use_regen,
  input  logic          status_clr,
  output logic          filt_hs,
  output logic          regen_hs,
  output logic          extra_seen,
  output logic          clkgen_hs,
  output logic          proc_hs
);
  localparam int PCW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] CMAX = '1;

  logic          sync_q, have_edge, prev_ok, locked, filt_r, extra_r;
  logic [CW-1:0] since, prev_int, per, ph;
  logic [PCW-1:0] rcnt;

  function automatic logic near(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW-1:0] d;
    d = (a > b) ? a - b : b - a;
    return d <= CW'(TOL);
  endfunction

  wire [CW:0] xz       = {{(CW + 1 - XW){1'b0}}, win_x};
  wire [CW:0] ph_ext   = {1'b0, ph};
  wire        early_ok = (ph_ext + xz) >= {1'b0, per};
  wire        late_ok  = ph_ext <= xz;
  wire        edge_w   = sync_in & ~sync_q;
  wire        in_win   = ~locked | early_ok | late_ok;
  wire        acc      = edge_w & in_win;
  wire        rej      = edge_w & ~in_win;
  wire        wrap     = locked & (ph >= per);
  wire        fire     = (acc & (~locked | ~late_ok)) | wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      have_edge <= 1'b0;
      prev_ok   <= 1'b0;
      locked    <= 1'b0;
      since     <= '0;
      prev_int  <= '0;
      per       <= '0;
      ph        <= '0;
    end else begin
      sync_q <= sync_in;
      if (acc) since <= CW'(1);
      else if (since != CMAX) since <= since + 1'b1;
      if (acc) have_edge <= 1'b1;
      if (acc && have_edge) begin
        if (!locked) begin
          prev_int <= since;
          prev_ok  <= 1'b1;
          if (prev_ok && near(since, prev_int)) begin
            locked <= 1'b1;
            per    <= since;
          end
        end else if (near(since, per)) begin
          per <= since;
        end
      end
      if (acc || wrap) ph <= CW'(1);
      else if (ph != CMAX) ph <= ph + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt    <= '0;
      filt_r  <= 1'b0;
      extra_r <= 1'b0;
    end else begin
      if (fire) rcnt <= PCW'(PULSE_LEN);
      else if (rcnt != '0) rcnt <= rcnt - 1'b1;
      filt_r  <= acc | (filt_r & sync_in);
      extra_r <= rej | (extra_r & ~status_clr);
    end
  end

  assign filt_hs    = filt_r;
  assign regen_hs   = rcnt != '0;
  assign extra_seen = extra_r;
  assign clkgen_hs  = use_filtered ? filt_r : sync_q;
  assign proc_hs    = use_regen ? regen_hs : sync_q;

  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !locked |-> !extra_r); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked); // R3
  AST_FREERUN_FIRES: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> regen_hs); // R4
  AST_REJECT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) rej |=> !filt_hs); // R7
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) rej |=> extra_seen); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) extra_r && !status_clr |=> extra_seen); // R8
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) locked && !acc |=> $stable(per)); // R11
endmodule

// File: tb/hsync_cleaner_tb.sv
module hsync_cleaner_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0;
  logic [7:0] win_x = 8'd4;
  logic use_filtered = 1'b1, use_regen = 1'b1, status_clr = 1'b0;
  logic filt_hs, regen_hs, extra_seen, clkgen_hs, proc_hs;

  hsync_cleaner dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .win_x(win_x),
    .use_filtered(use_filtered), .use_regen(use_regen), .status_clr(status_clr),
    .filt_hs(filt_hs), .regen_hs(regen_hs), .extra_seen(extra_seen),
    .clkgen_hs(clkgen_hs), .proc_hs(proc_hs));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic sync_smp = 1'b0, mon_clr = 1'b0, cmp_en = 1'b0, done = 1'b0;
  int n_filt, n_regen, n_clk, n_proc, filt_mis, run_len, last_w;
  int rise_t [0:15];
  logic p_filt, p_regen, p_clk, p_proc;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sync_smp <= sync_in;
  end

  always @(negedge clk) begin
    if (mon_clr) begin
      n_filt = 0; n_regen = 0; n_clk = 0; n_proc = 0; filt_mis = 0;
      run_len = 0; last_w = 0;
      p_filt = 0; p_regen = 0; p_clk = 0; p_proc = 0;
      for (int i = 0; i < 16; i++) rise_t[i] = 0;
    end else if (rst_n) begin
      if (filt_hs && !p_filt) n_filt++;
      if (clkgen_hs && !p_clk) n_clk++;
      if (proc_hs && !p_proc) n_proc++;
      if (regen_hs && !p_regen) begin
        if (n_regen < 16) rise_t[n_regen] = cyc;
        n_regen++;
      end
      if (regen_hs) run_len++;
      else if (p_regen) begin last_w = run_len; run_len = 0; end
      if (cmp_en && (filt_hs !== sync_smp)) filt_mis++;
      p_filt = filt_hs; p_regen = regen_hs; p_clk = clkgen_hs; p_proc = proc_hs;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int x);
    @(negedge clk);
    rst_n = 1'b0; sync_in = 1'b0; status_clr = 1'b0; win_x = 8'(x);
    repeat (3) @(negedge clk);
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic line(input int p);
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      sync_in = (i < 8);
    end
  endtask

  task automatic t_reset();
    do_reset(4);
    @(negedge clk);
    check("R1 filt_hs", int'(filt_hs), 0);
    check("R1 regen_hs", int'(regen_hs), 0);
    check("R1 extra_seen", int'(extra_seen), 0);
    check("R1 clkgen_hs", int'(clkgen_hs), 0);
    check("R1 proc_hs", int'(proc_hs), 0);
  endtask

  task automatic t_unlocked();
    do_reset(4);
    cmp_en = 1'b1;
    line(60); line(150); line(40); line(50);
    cmp_en = 1'b0;
    check("R2 filt copy mismatches", filt_mis, 0);
    check("R2 filt pulses", n_filt, 4);
    check("R2 flag clear", int'(extra_seen), 0);
    check("R2 regen per edge", n_regen, 4);
  endtask

  task automatic t_lock_tol();
    do_reset(4);
    line(100); line(102); line(300);
    check("R3 lock within 2 interval", rise_t[3] - rise_t[2], 102);
    check("R4 regen width", last_w, 32);
    do_reset(4);
    line(100); line(103); line(300);
    check("R3 no lock at 3 apart", n_regen, 3);
  endtask

  task automatic t_freerun();
    do_reset(4);
    line(100); line(100); line(450);
    check("R4 freerun count", n_regen, 7);
    check("R4 freerun spacing", rise_t[6] - rise_t[5], 100);
    check("R4 width", last_w, 32);
  endtask

  task automatic t_window();
    do_reset(4);
    line(100); line(100); line(96); line(250);
    check("R5 early 4 passes", n_filt, 4);
    check("R5 early 4 no flag", int'(extra_seen), 0);
    check("R6 early fires at edge", rise_t[3] - rise_t[2], 96);
    check("R6 next from early edge", rise_t[4] - rise_t[3], 100);
    do_reset(4);
    line(100); line(100); line(95); line(250);
    check("R5 early 5 blocked", n_filt, 3);
    check("R7 early 5 flags", int'(extra_seen), 1);
    check("R5 early 5 no rephase", rise_t[3] - rise_t[2], 100);
    do_reset(4);
    line(100); line(100); line(104); line(250);
    check("R5 late 4 passes", n_filt, 4);
    check("R5 late 4 no flag", int'(extra_seen), 0);
    check("R6 late no extra fire", rise_t[3] - rise_t[2], 100);
    check("R6 late rephase", rise_t[4] - rise_t[3], 104);
    do_reset(4);
    line(100); line(100); line(105); line(250);
    check("R5 late 5 blocked", n_filt, 3);
    check("R7 late 5 flags", int'(extra_seen), 1);
    check("R5 late 5 no rephase", rise_t[4] - rise_t[3], 100);
  endtask

  task automatic t_update();
    do_reset(4);
    line(100); line(100); line(99); line(300);
    check("R11 period updated", rise_t[4] - rise_t[3], 99);
    check("R11 period kept", rise_t[5] - rise_t[4], 99);
  endtask

  task automatic t_extra_mux();
    use_filtered = 1'b1; use_regen = 1'b0;
    do_reset(4);
    line(100); line(100); line(50); line(50); line(100); line(100);
    check("R7 extra blocked", n_filt, 5);
    check("R7 flag set", int'(extra_seen), 1);
    check("R9 clkgen filtered", n_clk, 5);
    check("R10 proc raw", n_proc, 6);
    line(100); line(100);
    check("R8 flag sticky", int'(extra_seen), 1);
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
    @(negedge clk);
    check("R8 flag cleared", int'(extra_seen), 0);
    use_filtered = 1'b0; use_regen = 1'b1;
    do_reset(4);
    line(100); line(100); line(50); line(50); line(100); line(100);
    check("R9 clkgen raw", n_clk, 6);
    check("R10 proc regen", n_proc, n_regen);
    check("R10 proc regen nonzero", int'(n_proc > 0), 1);
    use_filtered = 1'b1;
  endtask

  initial begin
    t_reset();
    t_unlocked();
    t_lock_tol();
    t_freerun();
    t_window();
    t_update();
    t_extra_mux();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule